// File: doc/BRIEF.md
# Two-Hit Pixel Time-Stamp Capture Cell

This cell is the digital front end of one pixel in a sparsified pixel matrix. It watches the output of the pixel's discriminator during an acquisition window. It keeps up to two hits, and each hit has its own copy of the shared time-stamp bus. While a capture stage is empty, its time-stamp register follows the bus. When that stage takes a hit, the register stops moving. Readout logic sees a valid flag and a frozen stamp for each stage. After readout it releases each stage on its own with a clear strobe.

Each pixel also holds a single kill bit. The kill bits of all pixels form one long serial chain with its own clock, and the chain is loaded from the matrix edge. A killed pixel reports nothing, and both of its stamp registers read zero. Before the hit input is used, it passes through a synchronizer. Only a low-to-high transition counts as a hit, so one long discriminator pulse takes only one stage.

Top module: `pixel_dual_hit_cell`

## Requirements
- R1: While rst_n is low, first_valid, second_valid, first_ts, second_ts and kmask_out are all 0.
- R2: hit_in passes two synchronizing flops before use, and only its 0-to-1 transitions count. A transition applied before clock edge k shows up as a valid flag after edge k+2. A pulse held high for any length fills at most one stage.
- R3: An accepted transition while stage one is empty sets first_valid. first_ts takes the ts_bus value present at that capturing edge and then holds it while first_valid stays set.
- R4: An accepted transition while stage one is full and stage two is empty sets second_valid. second_ts is frozen the same way, and first_ts does not change.
- R5: While a stage is empty and the pixel is not killed, its stamp output equals the ts_bus value sampled at the previous clock edge.
- R6: A transition that arrives while both stages are full is ignored: both flags and both stamps stay as they were.
- R7: While arm_n is high, transitions are not captured by either stage.
- R8: clr_first or clr_second, high at a clock edge, empties that stage at that edge, and the clear wins over a capture into the same stage in the same cycle. A new hit always goes to stage one when stage one is empty, even if stage two is full.
- R9: On every rising edge of kmask_clk, kmask_out takes the value of kmask_in. A 1 means the pixel is killed.
- R10: Two clock edges after the kill bit becomes 1, both valid flags are 0 and both stamps are 0. They stay that way, and hits are dropped, until the kill bit returns to 0.
- R11: The stamp width is a parameter with a default of 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Active-low master reset, asynchronous assert |
| arm_n | input | 1 | Active-low acquisition enable for hit capture |
| hit_in | input | 1 | Discriminator output, asynchronous |
| ts_bus | input | TS_W | Shared time-stamp bus |
| clr_first | input | 1 | Releases stage one after readout |
| clr_second | input | 1 | Releases stage two after readout |
| kmask_clk | input | 1 | Kill-chain shift clock |
| kmask_in | input | 1 | Kill-chain serial input from the previous pixel |
| kmask_out | output | 1 | Kill-chain serial output to the next pixel |
| first_valid | output | 1 | Stage one holds a hit |
| first_ts | output | TS_W | Stage one stamp |
| second_valid | output | 1 | Stage two holds a hit |
| second_ts | output | TS_W | Stage two stamp |

## Verification
The bench first applies single short pulses, which show the three-edge synchronizer latency and the exact stamp value frozen by each stage. A pulse held high for twenty cycles separates edge detection from level detection, because a level detector would fill the second stage as well. Pulses sent after both stages are full, pulses sent while disarmed, and a clear timed onto the same edge as a capture each show that a hit is dropped rather than stored. Toggling the kill chain around a stored hit, followed by a long pseudo-random mix of hits, clears and arming, exposes any ordering error between the stages against the cycle-level model.

// File: rtl/pixcell_pkg.sv
package pixcell_pkg;
  parameter int unsigned TS_W_DEFAULT  = 5;
  parameter int unsigned SYNC_DEFAULT  = 2;
  parameter int unsigned HIT_STAGES    = 2;
endpackage

// File: rtl/pixcell_sync.sv
module pixcell_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pixcell_hit_stage.sv
module pixcell_hit_stage #(
  parameter int unsigned TS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            clr,
  input  logic            killed,
  input  logic [TS_W-1:0] ts_bus,
  output logic            valid_o,
  output logic [TS_W-1:0] ts_o
);
  logic            valid_q, valid_n;
  logic [TS_W-1:0] ts_q, ts_n;
  logic            ts_en;

  // stamp register only moves while empty, or when forced clear by kill
  assign ts_en = killed | ~valid_q;

  always_comb begin
    valid_n = valid_q;
    ts_n    = ts_q;
    if (killed) begin
      valid_n = 1'b0;
      ts_n    = '0;
    end else begin
      valid_n = ~clr & (valid_q | take);
      ts_n    = ts_bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ts_q    <= '0;
    end else begin
      valid_q <= valid_n;
      if (ts_en) ts_q <= ts_n;
    end
  end

  assign valid_o = valid_q;
  assign ts_o    = ts_q;
endmodule

// File: rtl/pixcell_kill_bit.sv
module pixcell_kill_bit (
  input  logic kclk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic bit_q;

  always_ff @(posedge kclk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= din;
  end

  assign dout = bit_q;
endmodule

// File: rtl/pixel_dual_hit_cell.sv
module pixel_dual_hit_cell
  import pixcell_pkg::*;
#(
  parameter int unsigned TS_W        = TS_W_DEFAULT,
  parameter int unsigned SYNC_STAGES = SYNC_DEFAULT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm_n,
  input  logic            hit_in,
  input  logic [TS_W-1:0] ts_bus,
  input  logic            clr_first,
  input  logic            clr_second,
  input  logic            kmask_clk,
  input  logic            kmask_in,
  output logic            kmask_out,
  output logic            first_valid,
  output logic [TS_W-1:0] first_ts,
  output logic            second_valid,
  output logic [TS_W-1:0] second_ts
);
  localparam int unsigned NST = HIT_STAGES;

  logic            hit_s;
  logic            hit_prev_q;
  logic            hit_rise;
  logic            take;
  logic            masked;
  logic            kill_q;
  logic [NST-1:0]  valid_v;
  logic [NST-1:0]  clr_v;
  logic [NST-1:0]  take_v;
  logic [TS_W-1:0] ts_arr [NST];

  pixcell_sync #(.STAGES(SYNC_STAGES)) i_hit_sync (
    .clk(clk), .rst_n(rst_n), .d(hit_in), .q(hit_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_prev_q <= 1'b0;
    else        hit_prev_q <= hit_s;
  end

  assign hit_rise = hit_s & ~hit_prev_q;
  assign take     = hit_rise & ~arm_n & ~masked;

  pixcell_kill_bit i_kill (
    .kclk(kmask_clk), .rst_n(rst_n), .din(kmask_in), .dout(kill_q));

  pixcell_sync #(.STAGES(SYNC_STAGES)) i_kill_sync (
    .clk(clk), .rst_n(rst_n), .d(kill_q), .q(masked));

  assign clr_v = {clr_second, clr_first};

  // lowest empty stage takes the hit
  always_comb begin
    logic below_full;
    below_full = 1'b1;
    for (int i = 0; i < NST; i++) begin
      take_v[i]  = take & ~valid_v[i] & below_full;
      below_full = below_full & valid_v[i];
    end
  end

  for (genvar g = 0; g < NST; g++) begin : g_stage
    pixcell_hit_stage #(.TS_W(TS_W)) i_stage (
      .clk(clk), .rst_n(rst_n), .take(take_v[g]), .clr(clr_v[g]),
      .killed(masked), .ts_bus(ts_bus),
      .valid_o(valid_v[g]), .ts_o(ts_arr[g]));
  end

  assign kmask_out    = kill_q;
  assign first_valid  = valid_v[0];
  assign first_ts     = ts_arr[0];
  assign second_valid = valid_v[1];
  assign second_ts    = ts_arr[1];
endmodule

// File: rtl/pixel_dual_hit_cell_chk.sv
module pixel_dual_hit_cell_chk #(
  parameter int unsigned TS_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            arm_n,
  input logic [TS_W-1:0] ts_bus,
  input logic            clr_first,
  input logic            clr_second,
  input logic            kmask_clk,
  input logic            kmask_in,
  input logic            kmask_out,
  input logic            masked,
  input logic            first_valid,
  input logic [TS_W-1:0] first_ts,
  input logic            second_valid,
  input logic [TS_W-1:0] second_ts
);
  logic kseen_q;

  always_ff @(posedge kmask_clk or negedge rst_n) begin
    if (!rst_n) kseen_q <= 1'b0;
    else        kseen_q <= 1'b1;
  end

  AST_ONE_STAGE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(first_valid) && $rose(second_valid))); // R2

  AST_FIRST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (first_valid && !clr_first && !masked) |=> $stable(first_ts)); // R3

  AST_SECOND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (second_valid && !clr_second && !masked) |=> $stable(second_ts)); // R4

  AST_EMPTY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_valid && !masked) |=> (first_ts == $past(ts_bus))); // R5

  AST_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (first_valid && second_valid && !clr_first && !clr_second && !masked)
      |=> (first_valid && second_valid)); // R6

  AST_DISARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_n && !first_valid) |=> !first_valid); // R7

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_first || clr_second) |=>
      ((!$past(clr_first) || !first_valid) && (!$past(clr_second) || !second_valid))); // R8

  AST_KILL_SHIFT: assert property (@(posedge kmask_clk) disable iff (!rst_n)
    kseen_q |-> (kmask_out == $past(kmask_in))); // R9

  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    masked |=> (!first_valid && !second_valid && first_ts == '0 && second_ts == '0)); // R10
endmodule

bind pixel_dual_hit_cell pixel_dual_hit_cell_chk #(.TS_W(TS_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .arm_n(arm_n), .ts_bus(ts_bus),
  .clr_first(clr_first), .clr_second(clr_second),
  .kmask_clk(kmask_clk), .kmask_in(kmask_in), .kmask_out(kmask_out),
  .masked(masked), .first_valid(first_valid), .first_ts(first_ts),
  .second_valid(second_valid), .second_ts(second_ts));

// File: tb/test_pixel_dual_hit_cell.sv
`timescale 1ns/100ps
module test_pixel_dual_hit_cell;
  localparam int TS_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic arm_n = 1'b1;
  logic hit_in = 1'b0;
  logic [TS_W-1:0] ts_bus = '0;
  logic clr_first = 1'b0, clr_second = 1'b0;
  logic kmask_clk = 1'b0, kmask_in = 1'b0;
  logic kmask_out, first_valid, second_valid;
  logic [TS_W-1:0] first_ts, second_ts;

  int checks = 0, errs = 0, cyc = 0;
  bit started = 0, done = 0;

  pixel_dual_hit_cell #(.TS_W(TS_W), .SYNC_STAGES(2)) i_pixel_dual_hit_cell (
    .clk(clk), .rst_n(rst_n), .arm_n(arm_n), .hit_in(hit_in), .ts_bus(ts_bus),
    .clr_first(clr_first), .clr_second(clr_second),
    .kmask_clk(kmask_clk), .kmask_in(kmask_in), .kmask_out(kmask_out),
    .first_valid(first_valid), .first_ts(first_ts),
    .second_valid(second_valid), .second_ts(second_ts));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    #0.5;
    ts_bus = ts_bus + 1'b1;
  end

  // reference model
  int hq[$] = '{0, 0};
  int mq[$] = '{0, 0};
  int hp = 0, mk = 0;
  int mv1 = 0, mv2 = 0, mt1 = 0, mt2 = 0;

  always @(posedge kmask_clk or negedge rst_n) begin
    if (!rst_n) mk = 0;
    else        mk = int'(kmask_in);
  end

  always @(posedge clk or negedge rst_n) begin
    int rise, kill, tk, n1, n2;
    if (!rst_n) begin
      hq = '{0, 0}; mq = '{0, 0}; hp = 0;
      mv1 = 0; mv2 = 0; mt1 = 0; mt2 = 0;
    end else begin
      rise = (hq[0] == 1 && hp == 0) ? 1 : 0;
      kill = mq[0];
      tk   = (rise == 1 && arm_n == 1'b0 && kill == 0) ? 1 : 0;
      if (kill == 1) begin
        mv1 = 0; mv2 = 0; mt1 = 0; mt2 = 0;
      end else begin
        n1 = mv1; n2 = mv2;
        if (tk == 1 && mv1 == 0) n1 = 1;
        else if (tk == 1 && mv2 == 0) n2 = 1;
        if (clr_first)  n1 = 0;
        if (clr_second) n2 = 0;
        if (mv1 == 0) mt1 = int'(ts_bus);
        if (mv2 == 0) mt2 = int'(ts_bus);
        mv1 = n1; mv2 = n2;
      end
      hp = hq[0];
      void'(hq.pop_front()); hq.push_back(int'(hit_in));
      void'(mq.pop_front()); mq.push_back(mk);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R3 first_valid", int'(first_valid), mv1);
      chk("R3 first_ts", int'(first_ts), mt1);
      chk("R4 second_valid", int'(second_valid), mv2);
      chk("R4 second_ts", int'(second_ts), mt2);
      chk("R9 kmask_out", int'(kmask_out), mk);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      finish_run();
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic pulse();
    hit_in = 1'b1; tick(); tick(); hit_in = 1'b0;
  endtask

  task automatic kshift(bit b);
    kmask_in = b; #0.2; kmask_clk = 1'b1; #0.2; kmask_clk = 1'b0;
  endtask

  logic [TS_W-1:0] b1, b2, bp;
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) tick();
    chk("R1 first_valid", int'(first_valid), 0);
    chk("R1 second_valid", int'(second_valid), 0);
    chk("R1 first_ts", int'(first_ts), 0);
    chk("R1 second_ts", int'(second_ts), 0);
    chk("R1 kmask_out", int'(kmask_out), 0);
    rst_n = 1'b1; started = 1;
    arm_n = 1'b0;
    repeat (3) tick();
    // latency and first capture
    hit_in = 1'b1; tick();
    chk("R2 latency e1", int'(first_valid), 0);
    tick(); b1 = ts_bus;
    chk("R2 latency e2", int'(first_valid), 0);
    tick();
    chk("R3 set", int'(first_valid), 1);
    chk("R3 stamp", int'(first_ts), int'(b1));
    repeat (20) tick();
    chk("R2 long pulse one stage", int'(second_valid), 0);
    hit_in = 1'b0; repeat (3) tick();
    // second capture
    hit_in = 1'b1; tick(); tick(); b2 = ts_bus; tick();
    chk("R4 set", int'(second_valid), 1);
    chk("R4 stamp", int'(second_ts), int'(b2));
    chk("R4 first unchanged", int'(first_ts), int'(b1));
    hit_in = 1'b0; repeat (3) tick();
    // both full
    pulse(); repeat (5) tick();
    chk("R6 first_ts", int'(first_ts), int'(b1));
    chk("R6 second_ts", int'(second_ts), int'(b2));
    chk("R6 valids", int'({first_valid, second_valid}), 3);
    // release stage one
    clr_first = 1'b1; tick(); clr_first = 1'b0;
    chk("R8 cleared", int'(first_valid), 0);
    chk("R8 other kept", int'(second_valid), 1);
    bp = ts_bus; tick();
    chk("R5 tracking", int'(first_ts), int'(bp));
    pulse(); repeat (3) tick();
    chk("R8 refill stage one", int'(first_valid), 1);
    chk("R8 stage two kept", int'(second_ts), int'(b2));
    // clear beats same-cycle capture
    clr_first = 1'b1; clr_second = 1'b1; tick(); clr_first = 1'b0; clr_second = 1'b0;
    hit_in = 1'b1; tick(); tick(); clr_first = 1'b1; tick(); clr_first = 1'b0; hit_in = 1'b0;
    chk("R8 clear wins", int'(first_valid), 0);
    chk("R8 no spill", int'(second_valid), 0);
    // disarmed
    arm_n = 1'b1; pulse(); repeat (5) tick();
    chk("R7 disarmed", int'({first_valid, second_valid}), 0);
    arm_n = 1'b0;
    // kill mask
    pulse(); repeat (4) tick();
    chk("R10 pre-kill hit", int'(first_valid), 1);
    kshift(1'b1);
    chk("R9 shift one", int'(kmask_out), 1);
    repeat (4) tick();
    chk("R10 killed valid", int'(first_valid), 0);
    chk("R10 killed ts", int'(first_ts), 0);
    pulse(); repeat (5) tick();
    chk("R10 killed ignores", int'({first_valid, second_valid}), 0);
    chk("R10 killed ts2", int'(second_ts), 0);
    kshift(1'b0);
    chk("R9 shift zero", int'(kmask_out), 0);
    repeat (4) tick();
    pulse(); repeat (4) tick();
    chk("R10 unkilled", int'(first_valid), 1);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hit_in     = lfsr[0] & lfsr[3];
      clr_first  = (lfsr[7:5] == 3'd0);
      clr_second = (lfsr[10:8] == 3'd1);
      arm_n      = (lfsr[13:11] == 3'd7);
      if (lfsr[15:12] == 4'hF) kshift(lfsr[1]);
      tick();
    end
    hit_in = 1'b0; clr_first = 1'b0; clr_second = 1'b0; arm_n = 1'b0;
    // mid-run reset
    rst_n = 1'b0; tick();
    chk("R1 mid reset valids", int'({first_valid, second_valid}), 0);
    chk("R1 mid reset kill", int'(kmask_out), 0);
    rst_n = 1'b1; repeat (3) tick();
    chk("R11 stamp width", $bits(first_ts), 5);
    finish_run();
  end
endmodule